// File: doc/BRIEF.md
# Single-Wire Consumer-Control Bus Frame Receiver

This block listens to the shared open-drain control line of a video link and turns the pulse-width coded traffic on it into whole frames. Every edge on the line is timed against a 1 µs strobe. A long low pulse followed by a short high phase marks the start of a frame. After that, each bit begins with a falling edge, and its value is read at a fixed delay after that edge. Bits arrive in groups of ten per byte: eight payload bits with the most significant first, an end-of-message flag, and an acknowledge slot.

The receiver pulls the line low in the acknowledge slot when the frame is directed to one of its own logical addresses. Broadcast frames and frames for other nodes are not acknowledged. A bit period that is too short means some node broke the timing, so the receiver holds the line low for an extended error pulse. Timing that is too slow makes the receiver drop the frame without any signalling. A completed frame is given to the host side as a byte buffer, a byte count and a one-cycle strobe.

All timing limits are parameters expressed in strobe periods. Their defaults are the nominal µs values.

Top module: `cec_frame_rx`

## Requirements
- R1: A start pulse whose low phase lasts fewer than T_START_LOW_MIN (3500) strobes is rejected. The receiver goes back to idle, never pulls the line, and the previous buffer and length are kept.
- R2: The receiver returns to idle without delivering and without pulling the line in two cases: the line is still high more than T_START_TOTAL_MAX (4700) strobes after the start falling edge, or more than T_BIT_MAX (2750) strobes after a data-bit falling edge. An accepted start clears the buffer and the length to zero.
- R3: Each bit is read T_SAMPLE (850) strobes after its falling edge. A line still low reads as 0 and a released line reads as 1.
- R4: A data-bit falling edge that comes fewer than T_BIT_MIN (2050) strobes after the previous one makes the receiver pull the line low for T_ERR_LOW (3600) strobes. The receiver then returns to idle and accepts the next frame.
- R5: Payload bits are stored most significant first. Byte k of the frame sits at msg_data_o[8k+7:8k]. msg_len_o takes the value k+1 when byte k's end-of-message bit is read.
- R6: The destination is bits [3:0] of byte 0. When the destination is not 15 and own_addr_mask_i[destination] is 1, the receiver pulls the line low for T_ACK_LOW (1500) strobes from the falling edge of every acknowledge slot.
- R7: Destination 15 (broadcast) is never acknowledged, even when mask bit 15 is set. A destination whose mask bit is 0 is not acknowledged either. In both cases the frame is still delivered.
- R8: After the acknowledge slot that follows an end-of-message value of 1, msg_valid_o pulses once, T_ACK_END (1750) strobes after that slot's falling edge. The receiver then accepts a new frame.
- R9: At most MAX_BYTES (16) bytes are stored and msg_len_o never exceeds MAX_BYTES. Payload beyond that is dropped, but bit timing, acknowledge and delivery carry on.
- R10: msg_valid_o is high for exactly one clock. The buffer and length do not change from delivery until the next start pulse is accepted. After reset the length is 0, the line is released and no strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock strobe every 1 µs; all timing counts these |
| cec_in | input | 1 | Level of the shared open-drain line (high = released) |
| cec_pull_o | output | 1 | 1 pulls the line low (acknowledge or error pulse) |
| own_addr_mask_i | input | 16 | Bit n set: logical address n belongs to this node |
| msg_data_o | output | MAX_BYTES*8 | Received bytes, byte 0 in the lowest eight bits |
| msg_len_o | output | $clog2(MAX_BYTES+1) | Number of bytes in the last frame |
| msg_valid_o | output | 1 | One-clock strobe: a complete frame is available |

## Verification
The assertions assume the line only changes at a rate far below the clock rate and that tick_i keeps running while a frame is on the line. They also assume that no other node holds the line low during the receiver's own acknowledge or error pulse in a way that creates extra edges. The stimulus runs the strobe on every clock and drives the line through a wired-AND with the receiver's pull output, just as a real open-drain bus would behave. It also keeps every nominal pulse at least a few strobes away from each threshold, so the synchronizer delay cannot move a decision. The timing parameters are scaled down by ten in the bench to keep frames short, and the stimulus pulse widths are scaled to match.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_SLOW   = 3'd1,
        S_SHIGH  = 3'd2,
        S_DATA   = 3'd3,
        S_HIGH   = 3'd4,
        S_ACK    = 3'd5,
        S_LOWDRV = 3'd6
    } rx_state_e;

    localparam logic [3:0] BCAST_DEST = 4'hF;
    localparam logic [3:0] EOM_POS    = 4'd8;
    localparam logic [3:0] ACK_POS    = 4'd9;

endpackage

// File: rtl/cec_rx_edge.sv
module cec_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES:0] sync_q, sync_d;

    always_comb begin
        sync_d = {sync_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign level_o = sync_q[STAGES-1];
    assign fall_o  = sync_q[STAGES] & ~sync_q[STAGES-1];
    assign rise_o  = ~sync_q[STAGES] & sync_q[STAGES-1];
endmodule

// File: rtl/cec_rx_timer.sv
module cec_rx_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                      cnt_d = '0;
        else if (tick_i && cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx #(
    parameter int MAX_BYTES         = 16,
    parameter int T_START_LOW_MIN   = 3500,
    parameter int T_START_TOTAL_MAX = 4700,
    parameter int T_SAMPLE          = 850,
    parameter int T_BIT_MIN         = 2050,
    parameter int T_BIT_MAX         = 2750,
    parameter int T_ACK_LOW         = 1500,
    parameter int T_ACK_END         = 1750,
    parameter int T_ERR_LOW         = 3600,
    parameter int SYNC_STAGES       = 2,
    localparam int LEN_W            = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   cec_in,
    output logic                   cec_pull_o,
    input  logic [15:0]            own_addr_mask_i,
    output logic [MAX_BYTES*8-1:0] msg_data_o,
    output logic [LEN_W-1:0]       msg_len_o,
    output logic                   msg_valid_o
);
    import cec_rx_pkg::*;

    localparam int T_TOP = (T_START_TOTAL_MAX > T_ERR_LOW) ? T_START_TOTAL_MAX : T_ERR_LOW;
    localparam int CNT_W = $clog2(T_TOP + 2) + 1;
    localparam int BI_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    localparam logic [CNT_W-1:0] LIM_START_LOW = CNT_W'(T_START_LOW_MIN);
    localparam logic [CNT_W-1:0] LIM_START_MAX = CNT_W'(T_START_TOTAL_MAX);
    localparam logic [CNT_W-1:0] LIM_SAMPLE    = CNT_W'(T_SAMPLE);
    localparam logic [CNT_W-1:0] LIM_BIT_MIN   = CNT_W'(T_BIT_MIN);
    localparam logic [CNT_W-1:0] LIM_BIT_MAX   = CNT_W'(T_BIT_MAX);
    localparam logic [CNT_W-1:0] LIM_ACK_LOW   = CNT_W'(T_ACK_LOW);
    localparam logic [CNT_W-1:0] LIM_ACK_END   = CNT_W'(T_ACK_END);
    localparam logic [CNT_W-1:0] LIM_ERR       = CNT_W'(T_ERR_LOW);
    localparam logic [LEN_W-1:0] MAXB          = LEN_W'(MAX_BYTES);

    typedef struct packed {
        rx_state_e                   state;
        logic [3:0]                  bit_pos;
        logic [LEN_W-1:0]            byte_idx;
        logic                        eom;
        logic                        ack_me;
        logic [MAX_BYTES-1:0][7:0]   buffer;
        logic [LEN_W-1:0]            len;
        logic                        valid;
    } rx_regs_t;

    rx_regs_t         r_q, r_d;
    logic             level, fall, rise, clr;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       dest;
    logic             dest_hit;
    logic [BI_W-1:0]  wr_idx;

    cec_rx_edge #(.STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .line_i(cec_in),
        .level_o(level), .fall_o(fall), .rise_o(rise)
    );

    cec_rx_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clr_i(clr), .cnt_o(cnt)
    );

    assign dest     = r_q.buffer[0][3:0];
    assign dest_hit = (dest != BCAST_DEST) && own_addr_mask_i[dest];
    assign wr_idx   = r_q.byte_idx[BI_W-1:0];

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        clr       = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (fall) begin
                    clr       = 1'b1;
                    r_d.state = S_SLOW;
                end
            end
            S_SLOW: begin
                if (rise) begin
                    if (cnt < LIM_START_LOW) begin
                        r_d.state = S_IDLE;
                    end else begin
                        r_d.state    = S_SHIGH;
                        r_d.buffer   = '0;
                        r_d.len      = '0;
                        r_d.bit_pos  = '0;
                        r_d.byte_idx = '0;
                        r_d.eom      = 1'b0;
                        r_d.ack_me   = 1'b0;
                    end
                end
            end
            S_SHIGH: begin
                if (fall) begin
                    clr       = 1'b1;
                    r_d.state = S_DATA;
                end else if (cnt > LIM_START_MAX) begin
                    r_d.state = S_IDLE;
                end
            end
            S_DATA: begin
                if (cnt >= LIM_SAMPLE) begin
                    if (r_q.bit_pos < EOM_POS) begin
                        if (r_q.byte_idx < MAXB)
                            r_d.buffer[wr_idx][3'd7 - r_q.bit_pos[2:0]] = level;
                    end else begin
                        r_d.eom = level;
                        r_d.len = (r_q.byte_idx < MAXB) ? r_q.byte_idx + 1'b1 : MAXB;
                    end
                    r_d.bit_pos = r_q.bit_pos + 4'd1;
                    r_d.state   = S_HIGH;
                end
            end
            S_HIGH: begin
                if (fall) begin
                    clr = 1'b1;
                    if (cnt < LIM_BIT_MIN) begin
                        r_d.state = S_LOWDRV;
                    end else if (r_q.bit_pos == ACK_POS) begin
                        r_d.state  = S_ACK;
                        r_d.ack_me = dest_hit;
                    end else begin
                        r_d.state = S_DATA;
                    end
                end else if (level && cnt > LIM_BIT_MAX) begin
                    r_d.state = S_IDLE;
                end
            end
            S_ACK: begin
                if (cnt >= LIM_ACK_END) begin
                    if (r_q.eom) begin
                        r_d.valid = 1'b1;
                        r_d.state = S_IDLE;
                    end else begin
                        r_d.bit_pos  = '0;
                        r_d.byte_idx = (r_q.byte_idx == MAXB) ? MAXB : r_q.byte_idx + 1'b1;
                        r_d.state    = S_HIGH;
                    end
                end
            end
            S_LOWDRV: begin
                if (cnt >= LIM_ERR) r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cec_pull_o  = (r_q.state == S_LOWDRV) ||
                         (r_q.state == S_ACK && r_q.ack_me && cnt < LIM_ACK_LOW);
    assign msg_data_o  = r_q.buffer;
    assign msg_len_o   = r_q.len;
    assign msg_valid_o = r_q.valid;

    assert_start_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_SHIGH && $past(r_q.state) == S_SLOW) |-> $past(cnt) >= LIM_START_LOW);

    assert_bit_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_IDLE && $past(r_q.state) == S_HIGH) |-> $past(cnt) > LIM_BIT_MAX);

    assert_sample_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_HIGH && $past(r_q.state) == S_DATA) |-> $past(cnt) >= LIM_SAMPLE);

    assert_no_bcast_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_ACK && (dest == BCAST_DEST || !own_addr_mask_i[dest])) |-> !cec_pull_o);

    assert_valid_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> $past(r_q.state) == S_ACK);

    assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_len_o <= MAXB);

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |=> !msg_valid_o);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_IDLE) |=> ($stable(msg_data_o) && $stable(msg_len_o)));
endmodule

// File: tb/cec_frame_rx_tb_top.sv
`timescale 1ns/1ps
module cec_frame_rx_tb_top;
    localparam int MAXB     = 16;
    localparam int LEN_W    = $clog2(MAXB + 1);
    localparam int BIT1_LOW = 60;
    localparam int BIT0_LOW = 150;
    localparam int OBS      = 100;
    localparam int PER      = 240;
    localparam int ST_LOW   = 370;
    localparam int ST_PER   = 450;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [MAXB*8-1:0] data;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv = 1'b1;
    logic [15:0] mask = 16'h8010;
    logic line;
    logic pull;
    logic [MAXB*8-1:0] mdata;
    logic [LEN_W-1:0]  mlen;
    logic mvalid;

    int n_checks = 0;
    int n_fail = 0;
    exp_t exp_q[$];
    logic [7:0] frm [0:31];
    int pull_run = 0;
    int last_pull = 0;
    bit pull_seen = 0;
    bit prev_valid = 0;

    always #2.5 clk = ~clk;
    assign line = drv & ~pull;

    cec_frame_rx #(
        .MAX_BYTES(MAXB), .T_START_LOW_MIN(350), .T_START_TOTAL_MAX(470),
        .T_SAMPLE(85), .T_BIT_MIN(205), .T_BIT_MAX(275), .T_ACK_LOW(150),
        .T_ACK_END(175), .T_ERR_LOW(360)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(1'b1), .cec_in(line),
        .cec_pull_o(pull), .own_addr_mask_i(mask),
        .msg_data_o(mdata), .msg_len_o(mlen), .msg_valid_o(mvalid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected frames when the strobe appears, tracks pull pulses.
    always @(negedge clk) begin
        if (pull) begin
            pull_run++;
            pull_seen = 1'b1;
        end else if (pull_run > 0) begin
            last_pull = pull_run;
            pull_run = 0;
        end
        if (mvalid) begin
            chk(!prev_valid, "R10", "strobe longer than one clock", 2, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected delivery", {120'd0, 8'(mlen)}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(mlen == e.len, "R5", "length", 128'(mlen), 128'(e.len));
                chk(mdata == e.data, "R5", "data", mdata, e.data);
            end
        end
        prev_valid = mvalid;
    end

    task automatic send_bit(input logic v, output logic seen);
        drv = 1'b0;
        if (v) begin
            wait_c(BIT1_LOW); drv = 1'b1;
            wait_c(OBS - BIT1_LOW); seen = line;
            wait_c(PER - OBS);
        end else begin
            wait_c(OBS); seen = line;
            wait_c(BIT0_LOW - OBS); drv = 1'b1;
            wait_c(PER - BIT0_LOW);
        end
    endtask

    task automatic send_start(input int low, input int per);
        drv = 1'b0; wait_c(low);
        drv = 1'b1; wait_c(per - low);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic eom,
                             input bit check_ack, input logic exp_line, input string req);
        logic seen;
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], seen);
            if (check_ack) chk(seen == b[i], "R3", "line at sample point", 128'(seen), 128'(b[i]));
        end
        send_bit(eom, seen);
        send_bit(1'b1, seen);
        if (check_ack) chk(seen == exp_line, req, "acknowledge slot level", 128'(seen), 128'(exp_line));
    endtask

    task automatic send_frame(input int n, input logic acked, input string req);
        exp_t e;
        e.len = (n < MAXB) ? LEN_W'(n) : LEN_W'(MAXB);
        e.data = '0;
        for (int k = 0; k < n && k < MAXB; k++) e.data[k*8 +: 8] = frm[k];
        exp_q.push_back(e);
        send_start(ST_LOW, ST_PER);
        for (int k = 0; k < n; k++) send_byte(frm[k], k == n - 1, 1'b1, !acked, req);
        wait_c(120);
        chk(exp_q.size() == 0, "R8", "frame delivered", 128'(exp_q.size()), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic seen;
        logic [MAXB*8-1:0] held_d;
        logic [LEN_W-1:0]  held_l;
        wait_c(5);
        rst_n = 1'b1;
        wait_c(3);
        chk(pull == 1'b0, "R10", "reset pull", 128'(pull), 0);
        chk(mlen == '0, "R10", "reset length", 128'(mlen), 0);
        chk(mvalid == 1'b0, "R10", "reset strobe", 128'(mvalid), 0);

        // R6: directed to own address 4, acknowledged
        frm[0] = 8'h14; frm[1] = 8'h36;
        send_frame(2, 1'b1, "R6");
        chk(last_pull >= 148 && last_pull <= 154, "R6", "ack pull width", 128'(last_pull), 150);

        // R7: destination 5 not in mask
        frm[0] = 8'h15; frm[1] = 8'hA5;
        send_frame(2, 1'b0, "R7");

        // R7: broadcast with mask bit 15 set
        frm[0] = 8'h4F; frm[1] = 8'h00; frm[2] = 8'hFF;
        send_frame(3, 1'b0, "R7");

        // R5/R8: single-byte frame
        frm[0] = 8'h44;
        send_frame(1, 1'b1, "R6");

        // R1: short start pulse, whole frame ignored, buffer held (R10)
        held_d = mdata; held_l = mlen; pull_seen = 1'b0;
        send_start(300, ST_PER);
        send_byte(8'h14, 1'b1, 1'b0, 1'b0, "R1");
        wait_c(120);
        chk(pull_seen == 1'b0, "R1", "line pulled after rejected start", 1, 0);
        chk(mdata == held_d, "R1", "buffer held", mdata, held_d);
        chk(mlen == held_l, "R10", "length held", 128'(mlen), 128'(held_l));

        // R2: start high phase too long, accepted start cleared the buffer
        pull_seen = 1'b0;
        send_start(ST_LOW, 520);
        wait_c(400);
        chk(mlen == '0, "R2", "length cleared by accepted start", 128'(mlen), 0);
        chk(mdata == '0, "R2", "buffer cleared by accepted start", mdata, 0);
        chk(pull_seen == 1'b0, "R2", "no pull on start timeout", 1, 0);

        // R2: data bit high too long
        pull_seen = 1'b0;
        send_start(ST_LOW, ST_PER);
        send_bit(1'b0, seen);
        send_bit(1'b0, seen);
        drv = 1'b0; wait_c(BIT1_LOW); drv = 1'b1; wait_c(320 - BIT1_LOW);
        wait_c(300);
        chk(pull_seen == 1'b0, "R2", "no pull on bit timeout", 1, 0);
        frm[0] = 8'h24;
        send_frame(1, 1'b1, "R2");

        // R4: bit period too short -> error pulse
        send_start(ST_LOW, ST_PER);
        send_bit(1'b0, seen);
        send_bit(1'b1, seen);
        drv = 1'b0; wait_c(BIT1_LOW); drv = 1'b1; wait_c(180 - BIT1_LOW);
        drv = 1'b0; wait_c(BIT1_LOW); drv = 1'b1;
        wait_c(200 - BIT1_LOW);
        chk(line == 1'b0, "R4", "line held low by error pulse", 128'(line), 0);
        wait_c(300);
        chk(pull == 1'b0, "R4", "error pulse released", 128'(pull), 0);
        chk(last_pull >= 357 && last_pull <= 365, "R4", "error pulse width", 128'(last_pull), 360);
        frm[0] = 8'h34; frm[1] = 8'h9C;
        send_frame(2, 1'b1, "R4");

        // R9: overlong frame, first MAX_BYTES kept
        frm[0] = 8'h14;
        for (int k = 1; k < 18; k++) frm[k] = 8'(k * 8'h11 + 3);
        send_frame(18, 1'b1, "R9");
        chk(mlen == LEN_W'(MAXB), "R9", "length saturates", 128'(mlen), 128'(MAXB));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule